// File: doc/BRIEF.md
# Branch Resolution and Target Unit

This block settles the direction and destination of branches for a simple in-order fetch pipeline. Each cycle the fetch stage may present one decoded branch: its kind, its own address, a displacement, the index of the condition bit it tests, a static hint bit and a link flag. The block forms the target with its own adder, or takes it from a dedicated link or count register. It then drives the next fetch address in the same cycle the branch arrives.

A condition register of eight 4-bit fields carries a valid flag per field. An upstream unit announces a pending update to a field, which clears its flag, and later writes the field, which sets it again. If the tested field is valid when the branch arrives, the branch is resolved at once and costs no bubble. Otherwise fetch follows the hint, and the branch stays pending until the field becomes valid. If the real direction then disagrees with the hint, a one-cycle redirect gives the correct address.

The link and count registers can be loaded from, and read out to, a general register file through move ports.

Top module: `branch_resolve_unit`

## Requirements
- R1: A branch is accepted when `br_valid` is high and `stall` is low. Kind encoding on `br_kind`: 0 is an unconditional relative branch, 1 is a conditional relative branch, 2 is a conditional branch through the link register, and 3 is a conditional branch through the count register. For kinds 0 and 1 the target is `br_pc + br_disp`. `fetch_addr` shows the chosen address in the same cycle the branch is accepted, and is zero when no branch is accepted.
- R2: The tested condition bit is bit `br_crbit` of the condition register. Field f occupies bits 4f+3..4f, so the field index is `br_crbit[4:2]`. If the field is valid at acceptance, a conditional branch is resolved in that same cycle: `fetch_addr` is the target if the bit is 1 and `br_pc + 4` if it is 0, and no redirect follows.
- R3: Every target, fall-through and return address has its two low bits cleared.
- R4: An accepted branch with `br_link` set loads `br_pc + 4` into the link register, visible on `lr_out` the next cycle. This update wins over a move-to-link in the same cycle.
- R5: Kind 2 takes its target from the link register and kind 3 from the count register, using the values held at acceptance.
- R6: `mt_lr` and `mt_ctr` load `mt_data` into the link and count registers, visible on `lr_out` and `ctr_out` the next cycle. `lr_out` and `ctr_out` always show the current register values.
- R7: A conditional branch whose field is invalid at acceptance drives `fetch_addr` on the hinted path (`br_hint` = 1 means taken) and becomes pending. In the cycle after the field's write, `redirect` pulses for one cycle with `redirect_addr` set to the correct address, but only if the resolved direction differs from the hint.
- R8: `cr_claim` clears the valid flag of field `cr_claim_fld`. `cr_wr` writes `cr_wr_data` (data bit k to register bit 4f+k) and sets the flag. When both hit the same field in one cycle, the claim wins and the field stays invalid.
- R9: While a branch is pending, `stall` is high if a new branch is offered, or if `mt_lr` is requested while the pending kind is 2, or if `mt_ctr` is requested while the pending kind is 3. A stalled branch or move has no effect.
- R10: After reset the link, count and condition registers are zero, all fields are valid, nothing is pending, and `redirect` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch descriptor present |
| br_kind | input | 2 | Branch kind |
| br_pc | input | 32 | Address of the branch |
| br_disp | input | 32 | Relative displacement |
| br_crbit | input | 5 | Condition bit index |
| br_hint | input | 1 | Static prediction, 1 = taken |
| br_link | input | 1 | Write return address to link register |
| cr_claim | input | 1 | Announce pending field update |
| cr_claim_fld | input | 3 | Field being claimed |
| cr_wr | input | 1 | Write a condition field |
| cr_wr_fld | input | 3 | Field being written |
| cr_wr_data | input | 4 | Field value |
| mt_lr | input | 1 | Move general register to link register |
| mt_ctr | input | 1 | Move general register to count register |
| mt_data | input | 32 | Move data |
| lr_out | output | 32 | Link register value |
| ctr_out | output | 32 | Count register value |
| fetch_addr | output | 32 | Next fetch address for an accepted branch |
| redirect | output | 1 | Misprediction redirect pulse |
| redirect_addr | output | 32 | Corrected fetch address |
| stall | output | 1 | Request held off |

## Verification
`fetch_addr` and `stall` are combinational and are due in the cycle the stimulus is applied. Register updates on `lr_out` and `ctr_out` are due one cycle later. A redirect is due in the cycle after the condition field is written, and falls again the cycle after that. Each expected item carries the cycle number in which it is due. The monitor compares it only at that cycle's falling edge, after inputs set at the same falling edge have settled, so an early or late result is reported.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    BK_JUMP    = 2'd0,
    BK_COND    = 2'd1,
    BK_VIA_LR  = 2'd2,
    BK_VIA_CTR = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bru_target.sv
module bru_target #(
  parameter int AW = 32
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] lr,
  input  logic [AW-1:0] ctr,
  output logic [AW-1:0] tgt,
  output logic [AW-1:0] fall
);
  import bru_pkg::*;
  localparam logic [AW-1:0] ALIGN = ~AW'(3);
  logic [AW-1:0] sum;

  assign sum  = pc + disp;
  assign fall = (pc + AW'(4)) & ALIGN;

  always_comb begin
    case (br_kind_e'(kind))
      BK_VIA_LR:  tgt = lr & ALIGN;
      BK_VIA_CTR: tgt = ctr & ALIGN;
      default:    tgt = sum & ALIGN;
    endcase
  end
endmodule

// File: rtl/bru_cond_regs.sv
module bru_cond_regs #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  localparam int FLDW = $clog2(NFLD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [FLDW-1:0]  claim_fld,
  input  logic             wr,
  input  logic [FLDW-1:0]  wr_fld,
  input  logic [FW-1:0]    wr_data,
  output logic [NFLD*FW-1:0] cr,
  output logic [NFLD-1:0]  fld_vld
);
  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    logic [FW-1:0] val_q, val_d;
    logic          vld_q, vld_d;
    logic          hit_wr, hit_claim;

    assign hit_wr    = wr && (wr_fld == FLDW'(f));
    assign hit_claim = claim && (claim_fld == FLDW'(f));

    always_comb begin
      val_d = hit_wr ? wr_data : val_q;
      if (hit_claim)   vld_d = 1'b0;
      else if (hit_wr) vld_d = 1'b1;
      else             vld_d = vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        vld_q <= 1'b1;
      end else begin
        val_q <= val_d;
        vld_q <= vld_d;
      end
    end

    assign cr[f*FW +: FW] = val_q;
    assign fld_vld[f]     = vld_q;
  end
endmodule

// File: rtl/bru_spr_regs.sv
module bru_spr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_we,
  input  logic [AW-1:0] link_val,
  input  logic          lr_mv_en,
  input  logic          ctr_mv_en,
  input  logic [AW-1:0] mv_data,
  output logic [AW-1:0] lr,
  output logic [AW-1:0] ctr
);
  logic [AW-1:0] lr_d, ctr_d;

  always_comb begin
    if (link_we)       lr_d = link_val;
    else if (lr_mv_en) lr_d = mv_data;
    else               lr_d = lr;
    ctr_d = ctr_mv_en ? mv_data : ctr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr  <= '0;
      ctr <= '0;
    end else begin
      lr  <= lr_d;
      ctr <= ctr_d;
    end
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
  parameter int AW   = 32,
  parameter int NFLD = 8,
  parameter int FW   = 4,
  localparam int CRW  = NFLD * FW,
  localparam int SELW = $clog2(CRW),
  localparam int FLDW = $clog2(NFLD),
  localparam int BITW = $clog2(FW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [1:0]      br_kind,
  input  logic [AW-1:0]   br_pc,
  input  logic [AW-1:0]   br_disp,
  input  logic [SELW-1:0] br_crbit,
  input  logic            br_hint,
  input  logic            br_link,
  input  logic            cr_claim,
  input  logic [FLDW-1:0] cr_claim_fld,
  input  logic            cr_wr,
  input  logic [FLDW-1:0] cr_wr_fld,
  input  logic [FW-1:0]   cr_wr_data,
  input  logic            mt_lr,
  input  logic            mt_ctr,
  input  logic [AW-1:0]   mt_data,
  output logic [AW-1:0]   lr_out,
  output logic [AW-1:0]   ctr_out,
  output logic [AW-1:0]   fetch_addr,
  output logic            redirect,
  output logic [AW-1:0]   redirect_addr,
  output logic            stall
);
  import bru_pkg::*;

  logic [CRW-1:0]  cr;
  logic [NFLD-1:0] fld_vld;
  logic [AW-1:0]   tgt, fall;

  logic            pend_q, pend_d;
  br_kind_e        pkind_q, pkind_d;
  logic [AW-1:0]   ptgt_q, ptgt_d, pfall_q, pfall_d;
  logic            phint_q, phint_d;
  logic [SELW-1:0] psel_q, psel_d;

  logic accept, is_cond, now_vld, now_dir, resolve, res_dir;

  bru_cond_regs #(.NFLD(NFLD), .FW(FW)) u_cr (
    .clk(clk), .rst_n(rst_n),
    .claim(cr_claim), .claim_fld(cr_claim_fld),
    .wr(cr_wr), .wr_fld(cr_wr_fld), .wr_data(cr_wr_data),
    .cr(cr), .fld_vld(fld_vld)
  );

  bru_target #(.AW(AW)) u_tgt (
    .kind(br_kind), .pc(br_pc), .disp(br_disp),
    .lr(lr_out), .ctr(ctr_out), .tgt(tgt), .fall(fall)
  );

  // Hold-off: new branch, or a move into the register a pending branch reads
  assign stall = pend_q && (br_valid
                 || (mt_lr  && pkind_q == BK_VIA_LR)
                 || (mt_ctr && pkind_q == BK_VIA_CTR));

  assign accept  = br_valid && !stall;
  assign is_cond = br_kind_e'(br_kind) != BK_JUMP;
  assign now_vld = fld_vld[br_crbit[SELW-1:BITW]];
  assign now_dir = cr[br_crbit];

  bru_spr_regs #(.AW(AW)) u_spr (
    .clk(clk), .rst_n(rst_n),
    .link_we(accept && br_link), .link_val(fall),
    .lr_mv_en(mt_lr && !stall), .ctr_mv_en(mt_ctr && !stall),
    .mv_data(mt_data), .lr(lr_out), .ctr(ctr_out)
  );

  always_comb begin
    fetch_addr = '0;
    if (accept) begin
      if (!is_cond)     fetch_addr = tgt;
      else if (now_vld) fetch_addr = now_dir ? tgt : fall;
      else              fetch_addr = br_hint ? tgt : fall;
    end
  end

  assign resolve       = pend_q && fld_vld[psel_q[SELW-1:BITW]];
  assign res_dir       = cr[psel_q];
  assign redirect      = resolve && (res_dir != phint_q);
  assign redirect_addr = res_dir ? ptgt_q : pfall_q;

  always_comb begin
    pend_d  = pend_q;
    pkind_d = pkind_q;
    ptgt_d  = ptgt_q;
    pfall_d = pfall_q;
    phint_d = phint_q;
    psel_d  = psel_q;
    if (resolve) pend_d = 1'b0;
    if (accept && is_cond && !now_vld) begin
      pend_d  = 1'b1;
      pkind_d = br_kind_e'(br_kind);
      ptgt_d  = tgt;
      pfall_d = fall;
      phint_d = br_hint;
      psel_d  = br_crbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pkind_q <= BK_JUMP;
      ptgt_q  <= '0;
      pfall_q <= '0;
      phint_q <= 1'b0;
      psel_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      pkind_q <= pkind_d;
      ptgt_q  <= ptgt_d;
      pfall_q <= pfall_d;
      phint_q <= phint_d;
      psel_q  <= psel_d;
    end
  end
endmodule

// File: rtl/branch_resolve_unit_chk.sv
module branch_resolve_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic          br_link,
  input logic [AW-1:0] br_pc,
  input logic          mt_lr,
  input logic          mt_ctr,
  input logic [AW-1:0] mt_data,
  input logic [AW-1:0] lr_out,
  input logic [AW-1:0] ctr_out,
  input logic [AW-1:0] fetch_addr,
  input logic          redirect,
  input logic [AW-1:0] redirect_addr,
  input logic          stall
);
  p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  p_aligned_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[1:0] == 2'b00);

  p_aligned_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> redirect_addr[1:0] == 2'b00);

  p_link_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !stall && br_link) |=>
      lr_out == (($past(br_pc) + AW'(4)) & ~AW'(3)));

  p_ctr_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_ctr && !stall) |=> ctr_out == $past(mt_data));

  p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (br_valid || mt_lr || mt_ctr));

  p_stall_keeps_ctr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mt_ctr) |=> $stable(ctr_out));

  p_no_fetch_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid || stall) |-> fetch_addr == '0);
endmodule

bind branch_resolve_unit branch_resolve_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_link(br_link),
  .br_pc(br_pc), .mt_lr(mt_lr), .mt_ctr(mt_ctr), .mt_data(mt_data),
  .lr_out(lr_out), .ctr_out(ctr_out), .fetch_addr(fetch_addr),
  .redirect(redirect), .redirect_addr(redirect_addr), .stall(stall)
);

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
module branch_resolve_unit_test;
  localparam int S_FETCH = 0, S_REDIR = 1, S_RADDR = 2,
                 S_LR = 3, S_CTR = 4, S_STALL = 5;

  typedef struct {
    int          due;
    int          sig;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk, rst_n;
  logic        br_valid, br_hint, br_link;
  logic [1:0]  br_kind;
  logic [31:0] br_pc, br_disp, mt_data;
  logic [4:0]  br_crbit;
  logic        cr_claim, cr_wr, mt_lr, mt_ctr;
  logic [2:0]  cr_claim_fld, cr_wr_fld;
  logic [3:0]  cr_wr_data;
  logic [31:0] lr_out, ctr_out, fetch_addr, redirect_addr;
  logic        redirect, stall;

  int    cyc = 0, n_tests = 0, n_fail = 0;
  bit    done = 0;
  item_t q[$];

  branch_resolve_unit uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
    .br_pc(br_pc), .br_disp(br_disp), .br_crbit(br_crbit), .br_hint(br_hint),
    .br_link(br_link), .cr_claim(cr_claim), .cr_claim_fld(cr_claim_fld),
    .cr_wr(cr_wr), .cr_wr_fld(cr_wr_fld), .cr_wr_data(cr_wr_data),
    .mt_lr(mt_lr), .mt_ctr(mt_ctr), .mt_data(mt_data),
    .lr_out(lr_out), .ctr_out(ctr_out), .fetch_addr(fetch_addr),
    .redirect(redirect), .redirect_addr(redirect_addr), .stall(stall)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sig);
    case (sig)
      S_FETCH: return fetch_addr;
      S_REDIR: return {31'd0, redirect};
      S_RADDR: return redirect_addr;
      S_LR:    return lr_out;
      S_CTR:   return ctr_out;
      default: return {31'd0, stall};
    endcase
  endfunction

  // Monitor: compares every item due in the current cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          logic [31:0] act;
          act = observe(q[i].sig);
          n_tests++;
          if (act !== q[i].exp) begin
            n_fail++;
            $display("FAIL %s sig%0d cycle %0d: actual %h expected %h",
                     q[i].req, q[i].sig, cyc, act, q[i].exp);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int lag, int sig, logic [31:0] exp, string req);
    item_t it;
    it.due = cyc + lag; it.sig = sig; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic clr();
    br_valid = 0; br_kind = 0; br_pc = 0; br_disp = 0; br_crbit = 0;
    br_hint = 0; br_link = 0; cr_claim = 0; cr_claim_fld = 0; cr_wr = 0;
    cr_wr_fld = 0; cr_wr_data = 0; mt_lr = 0; mt_ctr = 0; mt_data = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clr();
  endtask

  task automatic branch(logic [1:0] k, logic [31:0] pc, logic [31:0] d,
                        logic [4:0] sel, logic h, logic l);
    br_valid = 1; br_kind = k; br_pc = pc; br_disp = d;
    br_crbit = sel; br_hint = h; br_link = l;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    step(); // R10 reset state
    expect_at(0, S_FETCH, 0, "R10"); expect_at(0, S_REDIR, 0, "R10");
    expect_at(0, S_LR, 0, "R10");    expect_at(0, S_CTR, 0, "R10");
    expect_at(0, S_STALL, 0, "R10");

    step(); // R1 R3 unconditional relative with link
    branch(2'd0, 32'h1000, 32'h23, 5'd0, 1'b0, 1'b1);
    expect_at(0, S_FETCH, 32'h1020, "R1");
    expect_at(1, S_LR, 32'h1004, "R4");

    step(); // R6 move to count; field 2 write sets cr bit 9
    mt_ctr = 1; mt_data = 32'h2007;
    cr_wr = 1; cr_wr_fld = 3'd2; cr_wr_data = 4'b0010;
    expect_at(1, S_CTR, 32'h2007, "R6");

    step(); // R5 R2 count-register branch resolved taken at receipt
    branch(2'd3, 32'h1100, 32'h0, 5'd9, 1'b0, 1'b0);
    expect_at(0, S_FETCH, 32'h2004, "R5");
    expect_at(1, S_REDIR, 0, "R2");

    step(); // R2 resolved not-taken at receipt despite hint
    branch(2'd1, 32'h1200, 32'h100, 5'd8, 1'b1, 1'b0);
    expect_at(0, S_FETCH, 32'h1204, "R2");

    step(); // R4 link branch beats move-to-link
    branch(2'd0, 32'h500, 32'h8, 5'd0, 1'b0, 1'b1);
    mt_lr = 1; mt_data = 32'h3000;
    expect_at(0, S_FETCH, 32'h508, "R1");
    expect_at(1, S_LR, 32'h504, "R4");

    step(); cr_claim = 1; cr_claim_fld = 3'd5;

    step(); // R7 predicted taken, field 5 invalid
    branch(2'd1, 32'h800, 32'h40, 5'd20, 1'b1, 1'b0);
    expect_at(0, S_FETCH, 32'h840, "R7");
    expect_at(0, S_REDIR, 0, "R7");

    step(); // R9 new branch while pending: stalled, no effect
    branch(2'd0, 32'h900, 32'h4, 5'd0, 1'b0, 1'b1);
    expect_at(0, S_STALL, 1, "R9");
    expect_at(0, S_FETCH, 0, "R9");
    expect_at(1, S_LR, 32'h504, "R9");

    step(); // R7 field resolves not-taken -> redirect to fall-through
    cr_wr = 1; cr_wr_fld = 3'd5; cr_wr_data = 4'b0000;
    expect_at(0, S_REDIR, 0, "R7");
    expect_at(1, S_REDIR, 1, "R7");
    expect_at(1, S_RADDR, 32'h804, "R7");

    step(); expect_at(1, S_REDIR, 0, "R7");

    step(); cr_claim = 1; cr_claim_fld = 3'd1;

    step(); // R7 link-register branch predicted not taken
    branch(2'd2, 32'hA00, 32'h0, 5'd4, 1'b0, 1'b0);
    expect_at(0, S_FETCH, 32'hA04, "R7");

    step(); // R9 move-to-link blocked while link branch pending
    mt_lr = 1; mt_data = 32'h7777;
    expect_at(0, S_STALL, 1, "R9");
    expect_at(1, S_LR, 32'h504, "R9");

    step(); // R9 move-to-count not blocked by link branch
    mt_ctr = 1; mt_data = 32'h1234;
    expect_at(0, S_STALL, 0, "R9");
    expect_at(1, S_CTR, 32'h1234, "R6");

    step(); // R5 R7 resolves taken -> redirect to held link value
    cr_wr = 1; cr_wr_fld = 3'd1; cr_wr_data = 4'b0001;
    expect_at(1, S_REDIR, 1, "R7");
    expect_at(1, S_RADDR, 32'h504, "R5");

    step();

    step(); // R8 claim and write same field: claim wins
    cr_claim = 1; cr_claim_fld = 3'd3;
    cr_wr = 1; cr_wr_fld = 3'd3; cr_wr_data = 4'b0001;

    step(); // R8 field still invalid so hint is followed
    branch(2'd1, 32'hC00, 32'h10, 5'd12, 1'b0, 1'b0);
    expect_at(0, S_FETCH, 32'hC04, "R8");

    step(); // R7 resolves matching hint: no redirect
    cr_wr = 1; cr_wr_fld = 3'd3; cr_wr_data = 4'b0000;
    expect_at(1, S_REDIR, 0, "R7");

    step();

    step(); // R8 write made field valid; R2 resolved at receipt
    branch(2'd1, 32'hD00, 32'h20, 5'd12, 1'b1, 1'b0);
    expect_at(0, S_FETCH, 32'hD04, "R8");
    expect_at(0, S_STALL, 0, "R9");

    step();
    step();
    done = 1;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", q.size());
    end
    summary();
    $finish;
  end
endmodule